// File: doc/BRIEF.md
# Block-Burst Bus Arbiter for Eight DMA Channels

This block decides which of eight DMA channels owns a shared bus. A channel raises its request line when it has a block ready to move. The arbiter picks one requester, drives a one-hot grant with a valid flag, and keeps that grant until the owning channel pulses its block-done line. A block is therefore never split and never preempted, whatever happens on the other inputs in the meantime.

Two policies are available and can be switched at run time. With the policy select low, the requester with the lowest channel number wins. With it high, the search starts at the channel after the most recent winner and wraps from the highest channel back to channel 0. A global enable gates every new grant. When the previous owner finishes, the next grant can be issued on the very next cycle.

Top module: `burst_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the grant vector is all zero and the valid flag is low.
- R2: At most one grant bit is high in any cycle, and the valid flag is high exactly when one grant bit is high.
- R3: With `rr_sel` = 0, a new grant goes to the lowest-numbered channel whose request bit is high (bit i of `ch_req` and `bus_gnt` is channel i).
- R4: With `rr_sel` = 1, a new grant goes to the first requester found when scanning upward from the channel after the last winner, wrapping from channel 7 to channel 0. After reset the scan starts at channel 0.
- R5: Once granted, a channel keeps the grant, unchanged, until its own `ch_done` bit is high. Changes on requests, policy select or enable do not move the grant.
- R6: A `ch_done` bit of a channel that does not hold the grant has no effect on the grant.
- R7: In a cycle where the owner's done bit is high and the enable is high with at least one request pending, the next grant appears in the following cycle, with no idle cycle between.
- R8: While `arb_en` is low no new grant is issued. A grant already held when the enable drops stays until its done, after which the valid flag falls.
- R9: When the bus is free (no owner, or the owner's done is high) and no request is high, the valid flag is low in the next cycle.
- R10: A change of `rr_sel` applies to the next arbitration. The round-robin position always follows the last granted channel, including grants made under the fixed policy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_req | input | NUM_CH | Per-channel block request |
| ch_done | input | NUM_CH | Per-channel block-complete pulse |
| rr_sel | input | 1 | Policy select: 0 fixed priority, 1 round robin |
| arb_en | input | 1 | Global enable for new grants |
| bus_gnt | output | NUM_CH | One-hot grant |
| gnt_valid | output | 1 | A grant is currently held |

## Verification
The assertions take for granted that the inputs are stable around the rising edge and that a done bit for a non-owner can show up at any time. They do not assume that a channel drops its request once it is served. The bench drives every input only at falling edges. Alongside full sweeps of all 256 request patterns under both policies, it gives the inputs free values that include stray done bits, enable drops in the middle of a block and policy flips while a block is in flight. This keeps the stimulus inside those assumptions while still reaching every hand-off case.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;
  localparam int unsigned ARB_DEF_CH = 8;

  typedef enum logic {
    POL_FIXED  = 1'b0,
    POL_ROTATE = 1'b1
  } arb_pol_e;
endpackage

// File: rtl/arb_pick.sv
// Combinational winner search: both policies are evaluated, the select picks one.
module arb_pick #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  input  logic          rotate,
  output logic          found,
  output logic [IW-1:0] win
);
  // Lowest index wins: scan downward so the last hit is the lowest.
  function automatic logic [IW:0] scan_fixed(input logic [N-1:0] r);
    logic [IW:0] res;
    res = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (r[i]) res = {1'b1, IW'(i)};
    end
    return res;
  endfunction

  // Offsets 1..N past the last winner; scan down so the smallest offset wins.
  function automatic logic [IW:0] scan_rotate(input logic [N-1:0] r, input logic [IW-1:0] l);
    logic [IW:0] res;
    res = '0;
    for (int unsigned k = N; k >= 1; k--) begin
      int unsigned j;
      j = (32'(l) + k) % N;
      if (r[j]) res = {1'b1, IW'(j)};
    end
    return res;
  endfunction

  logic [IW:0] fix_res;
  logic [IW:0] rot_res;

  assign fix_res      = scan_fixed(req);
  assign rot_res      = scan_rotate(req, last);
  assign {found, win} = rotate ? rot_res : fix_res;
endmodule

// File: rtl/arb_owner.sv
// Ownership state: current grant, busy flag and last winner.
module arb_owner #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_free,
  input  logic          take_grant,
  input  logic [IW-1:0] win,
  output logic [N-1:0]  gnt_q,
  output logic          busy_q,
  output logic [IW-1:0] last_q
);
  function automatic logic [N-1:0] to_onehot(input logic [IW-1:0] idx);
    return N'(1) << idx;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      busy_q <= 1'b0;
      last_q <= IW'(N - 1);
    end else if (take_grant) begin
      gnt_q  <= to_onehot(win);
      busy_q <= 1'b1;
      last_q <= win;
    end else if (slot_free) begin
      gnt_q  <= '0;
      busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_arbiter.sv
module burst_arbiter #(
  parameter int unsigned NUM_CH = dmaarb_pkg::ARB_DEF_CH,
  localparam int unsigned IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_req,
  input  logic [NUM_CH-1:0] ch_done,
  input  logic              rr_sel,
  input  logic              arb_en,
  output logic [NUM_CH-1:0] bus_gnt,
  output logic              gnt_valid
);
  import dmaarb_pkg::*;

  arb_pol_e          pol;
  logic [NUM_CH-1:0] done_hit;
  logic              owner_done;
  logic              slot_free;
  logic              pick_found;
  logic [IW-1:0]     pick_idx;
  logic [IW-1:0]     last_idx;
  logic              take_grant;

  assign pol = arb_pol_e'(rr_sel);

  // Only the owner's done bit counts.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_done
    assign done_hit[g] = bus_gnt[g] & ch_done[g];
  end

  assign owner_done = |done_hit;
  assign slot_free  = !gnt_valid || owner_done;
  assign take_grant = slot_free && arb_en && pick_found;

  arb_pick #(.N(NUM_CH)) u_pick (
    .req    (ch_req),
    .last   (last_idx),
    .rotate (pol == POL_ROTATE),
    .found  (pick_found),
    .win    (pick_idx)
  );

  arb_owner #(.N(NUM_CH)) u_owner (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_free  (slot_free),
    .take_grant (take_grant),
    .win        (pick_idx),
    .gnt_q      (bus_gnt),
    .busy_q     (gnt_valid),
    .last_q     (last_idx)
  );
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] ch_req,
  input logic [N-1:0] ch_done,
  input logic         rr_sel,
  input logic         arb_en,
  input logic [N-1:0] bus_gnt,
  input logic         gnt_valid,
  input logic         slot_free
);
  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_gnt));

  // R2
  valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid == ($countones(bus_gnt) == 1));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !(|(bus_gnt & ch_done))) |=> (gnt_valid && bus_gnt == $past(bus_gnt)));

  // R8
  no_grant_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_free && !arb_en) |=> !gnt_valid);

  // R7
  handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_free && arb_en && |ch_req) |=> (gnt_valid && |(bus_gnt & $past(ch_req))));

  // R3
  fixed_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_free && arb_en && !rr_sel && |ch_req) |=> bus_gnt == $past(ch_req & (~ch_req + N'(1))));

  // R9
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_free && !(|ch_req)) |=> !gnt_valid);
endmodule

bind burst_arbiter arb_chk #(.N(NUM_CH)) u_arb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ch_req    (ch_req),
  .ch_done   (ch_done),
  .rr_sel    (rr_sel),
  .arb_en    (arb_en),
  .bus_gnt   (bus_gnt),
  .gnt_valid (gnt_valid),
  .slot_free (slot_free)
);

// File: tb/sim_burst_arbiter.sv
module sim_burst_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NC-1:0] ch_req, ch_done;
  logic          rr_sel, arb_en;
  logic [NC-1:0] bus_gnt;
  logic          gnt_valid;

  int vectors = 0;
  int fails = 0;
  bit checking = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  burst_arbiter #(.NUM_CH(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_done(ch_done),
    .rr_sel(rr_sel), .arb_en(arb_en), .bus_gnt(bus_gnt), .gnt_valid(gnt_valid)
  );

  // Reference model, written arithmetically.
  logic [NC-1:0] e_gnt;
  logic          e_valid;
  int            e_last;
  logic          e_mode_last;
  string         e_tag;

  function automatic int low_idx(input logic [NC-1:0] r);
    logic [NC-1:0] lb;
    lb = r & (~r + 8'd1);
    return $clog2(lb);
  endfunction

  function automatic int rot_idx(input logic [NC-1:0] r, input int last);
    logic [2*NC-1:0] dbl;
    int sh;
    sh  = (last + 1) % NC;
    dbl = {r, r} >> sh;
    return (sh + low_idx(dbl[NC-1:0])) % NC;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_gnt <= '0; e_valid <= 1'b0; e_last <= NC - 1; e_mode_last <= 1'b0; e_tag <= "R1";
    end else begin
      bit free;
      int idx;
      free = !e_valid || ((e_gnt & ch_done) != 0);
      if (free && arb_en && ch_req != 0) begin
        idx = rr_sel ? rot_idx(ch_req, e_last) : low_idx(ch_req);
        e_gnt <= 8'd1 << idx;
        e_valid <= 1'b1;
        e_last <= idx;
        e_mode_last <= rr_sel;
        if (rr_sel != e_mode_last) e_tag <= "R10";
        else if (e_valid) e_tag <= "R7";
        else e_tag <= rr_sel ? "R4" : "R3";
      end else if (free) begin
        e_gnt <= '0;
        e_valid <= 1'b0;
        e_tag <= (!arb_en && ch_req != 0) ? "R8" : "R9";
      end else begin
        e_tag <= ((ch_done & ~e_gnt) != 0) ? "R6" : (!arb_en ? "R8" : "R5");
      end
    end
  end

  // Compare at falling edges.
  always @(negedge clk) begin
    if (checking) begin
      vectors++;
      if (bus_gnt !== e_gnt || gnt_valid !== e_valid) begin
        fails++;
        $display("FAIL %s: gnt=%b valid=%b expected gnt=%b valid=%b",
                 e_tag, bus_gnt, gnt_valid, e_gnt, e_valid);
      end
      vectors++;
      if ($countones(bus_gnt) > 1 || gnt_valid !== (bus_gnt != 0)) begin
        fails++;
        $display("FAIL R2: gnt=%b valid=%b expected onehot0 with matching valid",
                 bus_gnt, gnt_valid);
      end
    end
  end

  task automatic step(input logic [NC-1:0] r, input logic [NC-1:0] d,
                      input logic m, input logic e);
    @(negedge clk);
    ch_req = r; ch_done = d; rr_sel = m; arb_en = e;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; ch_req = '0; ch_done = '0; rr_sel = 1'b0; arb_en = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    vectors++;
    if (bus_gnt !== '0 || gnt_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: gnt=%b valid=%b expected gnt=00000000 valid=0", bus_gnt, gnt_valid);
    end
    rst_n = 1'b1;
    checking = 1'b1;

    // R3 sweep of every request pattern, fixed policy
    for (int p = 0; p < 256; p++) begin
      step(8'(p), '0, 1'b0, 1'b1);
      step('0, e_gnt, 1'b0, 1'b1);
    end
    // R4 sweep under round robin, two passes so the start point moves
    for (int pass = 0; pass < 2; pass++) begin
      for (int p = 0; p < 256; p++) begin
        step(8'(p), '0, 1'b1, 1'b1);
        step(8'(p), e_gnt, 1'b1, 1'b1);
      end
      step('0, e_gnt, 1'b1, 1'b1);
    end

    // R8 enable dropped during a block
    step(8'h10, '0, 1'b0, 1'b1);
    step(8'hFF, '0, 1'b0, 1'b0);
    step(8'hFF, 8'h0F, 1'b1, 1'b0);
    step(8'hFF, '0, 1'b0, 1'b0);
    step(8'hFF, e_gnt, 1'b0, 1'b0);
    step(8'hFF, '0, 1'b0, 1'b0);
    step('0, '0, 1'b0, 1'b1);

    // R5 R6 R7 R10 free-running mix
    for (int k = 0; k < 4000; k++) begin
      logic m;
      logic [NC-1:0] d;
      m = ((k / 37) % 2) == 1;
      d = (($urandom % 3) == 0) ? e_gnt : '0;
      if (($urandom % 4) == 0) d = d | (8'($urandom) & ~e_gnt);
      step(8'($urandom), d, m, ($urandom % 5) != 0);
    end

    step('0, e_gnt, 1'b0, 1'b1);
    @(negedge clk);
    checking = 1'b0;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end
endmodule